// File: doc/BRIEF.md
# Load/Store Alignment and Extension Unit

This unit sits between a 32-bit core and a byte-addressed data memory that is 32 bits wide. For each memory request it forms the effective address from a base register and a signed 16-bit displacement. It checks that the access is naturally aligned and that a user-mode request stays below the kernel half of the address space. It then produces the lane write enables and lane-steered store data that the memory port needs. Lanes are big-endian: byte offset 0 within a word occupies data bits 31:24.

Requests enter on a valid/ready channel. The formatted access leaves on a registered valid/ready channel towards memory. A request is taken when `req_valid` and `req_ready` are both high. `req_ready` is high whenever the output slot is empty or is being drained in the same cycle. While `acc_valid` is high and `acc_ready` is low, every `acc_*` output holds still and no new request is taken. An access that fails a check still flows out, with `acc_err` set, a load or store code, the faulting address and an all-zero lane mask, so the core can record it. Load return data takes a separate combinational path. It picks the addressed byte or halfword out of the returned word and sign- or zero-extends it.

Size encoding on `req_size` and `ld_size`: 00 byte, 01 halfword, 10 word, 11 treated as word.

Top module: `lsu_align_unit`

## Requirements
- R1: `acc_addr` equals `req_base` plus `req_disp` sign-extended to 32 bits, modulo 2^32. This holds whether or not the access is in error.
- R2: A halfword access with address bit 0 set, or a word access with either of address bits 1:0 set, raises `acc_err`. A byte access is never misaligned.
- R3: When `req_user` is 1 and the effective address is at or above 0x8000_0000, `acc_err` is raised. In kernel mode (`req_user` 0) the upper half is allowed.
- R4: `acc_code` is 4 for a failed load, 5 for a failed store and 0 when there is no error. `acc_store` echoes `req_store`.
- R5: `acc_be` bit 3 covers data bits 31:24 and bit 0 covers bits 7:0. A word access gives 1111. A halfword gives 1100 at offset 0 and 0011 at offset 2. A byte at offset k gives a single 1 at bit 3-k. On an error the mask is 0000. The same mask applies to loads and stores.
- R6: Store data puts the low 8 bits of `req_wdata` into all four lanes for a byte access and the low 16 bits into both halves for a halfword. A word is passed through unchanged.
- R7: For a byte load, `ld_value` is the byte at lane `ld_lane` (offset 0 is bits 31:24). It is zero-extended when `ld_unsigned` is 1 and otherwise filled with 24 copies of its bit 7.
- R8: For a halfword load, `ld_lane` bit 1 selects bits 31:16 (0) or bits 15:0 (1). The halfword is extended from its bit 15 in the same way. A word load returns `ld_word` unchanged.
- R9: `req_ready` equals `!acc_valid || acc_ready`. An accepted request appears on the `acc_*` outputs in the next cycle with `acc_valid` high. While `acc_valid && !acc_ready`, all `acc_*` outputs stay stable.
- R10: After reset `acc_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_base | input | 32 | Base register value |
| req_disp | input | 16 | Signed displacement |
| req_size | input | 2 | Access size (00 byte, 01 half, 10/11 word) |
| req_store | input | 1 | 1 store, 0 load |
| req_user | input | 1 | 1 when the core runs in user mode |
| req_wdata | input | 32 | Store source register value |
| acc_valid | output | 1 | Formatted access present |
| acc_ready | input | 1 | Memory side takes the access |
| acc_addr | output | 32 | Effective (or faulting) address |
| acc_be | output | 4 | Lane enables, bit 3 = bits 31:24 |
| acc_wdata | output | 32 | Lane-steered store data |
| acc_store | output | 1 | Access is a store |
| acc_err | output | 1 | Alignment or privilege error |
| acc_code | output | 5 | 4 load error, 5 store error, 0 none |
| ld_word | input | 32 | Word returned by memory |
| ld_lane | input | 2 | Byte offset of the load |
| ld_size | input | 2 | Load size |
| ld_unsigned | input | 1 | 1 zero-extend, 0 sign-extend |
| ld_value | output | 32 | Extended load result |

## Verification
The misalignment check and the user-mode privilege check can both trip on the same access. An example is a user-mode word load at 0x8000_0002. The bench provokes this case directly, and the random stream also hits it often because it draws the base's top bit, the mode and the low address bits independently. The bench expects a single error with the load or store code, an all-zero lane mask and the full faulting address. A second overlap is that a new request can be accepted in the same cycle as the held one drains. This is covered by holding `acc_ready` low across a second offered request and then releasing it.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_WIDE = 2'b11
  } lsu_size_e;

  localparam int CODE_W = 5;
  localparam logic [CODE_W-1:0] CODE_NONE     = 5'd0;
  localparam logic [CODE_W-1:0] CODE_LOAD_BAD = 5'd4;
  localparam logic [CODE_W-1:0] CODE_STOR_BAD = 5'd5;
endpackage

// File: rtl/lsu_agen.sv
module lsu_agen
  import lsu_pkg::*;
#(
  parameter int AW   = 32,
  parameter int OFFW = 16
) (
  input  logic [AW-1:0]   base,
  input  logic [OFFW-1:0] disp,
  input  logic [1:0]      size,
  input  logic            user,
  output logic [AW-1:0]   ea,
  output logic            misaligned,
  output logic            priv_fault
);
  localparam int EXT = AW - OFFW;

  lsu_size_e sz;
  assign sz = lsu_size_e'(size);
  assign ea = base + {{EXT{disp[OFFW-1]}}, disp};

  always_comb begin
    unique case (sz)
      SZ_BYTE: misaligned = 1'b0;
      SZ_HALF: misaligned = ea[0];
      default: misaligned = |ea[1:0];
    endcase
  end

  // upper half of the space belongs to the kernel
  assign priv_fault = user & ea[AW-1];
endmodule

// File: rtl/lsu_store_lane.sv
module lsu_store_lane
  import lsu_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0]   src,
  input  logic [1:0]      size,
  input  logic [1:0]      offs,
  input  logic            kill,
  output logic [DW/8-1:0] be,
  output logic [DW-1:0]   data
);
  localparam int NL = DW / 8;

  lsu_size_e sz;
  assign sz = lsu_size_e'(size);

  int unsigned first;
  int unsigned span;
  always_comb begin
    unique case (sz)
      SZ_BYTE: begin first = 32'(offs);              span = 1;  end
      SZ_HALF: begin first = 32'({offs[1], 1'b0});  span = 2;  end
      default: begin first = 0;                      span = NL; end
    endcase
  end

  for (genvar k = 0; k < NL; k++) begin : g_lane
    // lane k is byte offset k, placed big-endian
    localparam int HI = DW - 1 - 8 * k;
    assign be[NL-1-k] = !kill && (k >= first) && (k < first + span);
    always_comb begin
      unique case (sz)
        SZ_BYTE: data[HI -: 8] = src[7:0];
        SZ_HALF: data[HI -: 8] = (k % 2 == 0) ? src[15:8] : src[7:0];
        default: data[HI -: 8] = src[HI -: 8];
      endcase
    end
  end
endmodule

// File: rtl/lsu_load_ext.sv
module lsu_load_ext
  import lsu_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] word,
  input  logic [1:0]    lane,
  input  logic [1:0]    size,
  input  logic          zext,
  output logic [DW-1:0] value
);
  localparam int NL = DW / 8;

  lsu_size_e sz;
  assign sz = lsu_size_e'(size);

  logic [7:0] bytes [NL];
  for (genvar k = 0; k < NL; k++) begin : g_pick
    assign bytes[k] = word[DW-1-8*k -: 8];
  end

  logic [7:0]  b_sel;
  logic [15:0] h_sel;
  assign b_sel = bytes[lane];
  assign h_sel = lane[1] ? {bytes[2], bytes[3]} : {bytes[0], bytes[1]};

  always_comb begin
    unique case (sz)
      SZ_BYTE: value = {{(DW-8){b_sel[7] & !zext}}, b_sel};
      SZ_HALF: value = {{(DW-16){h_sel[15] & !zext}}, h_sel};
      default: value = word;
    endcase
  end
endmodule

// File: rtl/lsu_align_unit.sv
module lsu_align_unit
  import lsu_pkg::*;
#(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int OFFW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [AW-1:0]     req_base,
  input  logic [OFFW-1:0]   req_disp,
  input  logic [1:0]        req_size,
  input  logic              req_store,
  input  logic              req_user,
  input  logic [DW-1:0]     req_wdata,
  output logic              acc_valid,
  input  logic              acc_ready,
  output logic [AW-1:0]     acc_addr,
  output logic [DW/8-1:0]   acc_be,
  output logic [DW-1:0]     acc_wdata,
  output logic              acc_store,
  output logic              acc_err,
  output logic [CODE_W-1:0] acc_code,
  input  logic [DW-1:0]     ld_word,
  input  logic [1:0]        ld_lane,
  input  logic [1:0]        ld_size,
  input  logic              ld_unsigned,
  output logic [DW-1:0]     ld_value
);
  localparam int NL = DW / 8;

  logic [AW-1:0] ea;
  logic          mis, prv, bad;
  logic [NL-1:0] be_n;
  logic [DW-1:0] wd_n;

  lsu_agen #(.AW(AW), .OFFW(OFFW)) u_agen (
    .base(req_base), .disp(req_disp), .size(req_size), .user(req_user),
    .ea(ea), .misaligned(mis), .priv_fault(prv)
  );

  assign bad = mis | prv;

  lsu_store_lane #(.DW(DW)) u_lane (
    .src(req_wdata), .size(req_size), .offs(ea[1:0]), .kill(bad),
    .be(be_n), .data(wd_n)
  );

  lsu_load_ext #(.DW(DW)) u_ext (
    .word(ld_word), .lane(ld_lane), .size(ld_size), .zext(ld_unsigned),
    .value(ld_value)
  );

  logic take;
  assign req_ready = !acc_valid || acc_ready;
  assign take      = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_valid <= 1'b0;
      acc_addr  <= '0;
      acc_be    <= '0;
      acc_wdata <= '0;
      acc_store <= 1'b0;
      acc_err   <= 1'b0;
      acc_code  <= CODE_NONE;
    end else if (take) begin
      acc_valid <= 1'b1;
      acc_addr  <= ea;
      acc_be    <= be_n;
      acc_wdata <= wd_n;
      acc_store <= req_store;
      acc_err   <= bad;
      acc_code  <= !bad ? CODE_NONE : (req_store ? CODE_STOR_BAD : CODE_LOAD_BAD);
    end else if (acc_ready) begin
      acc_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/lsu_align_unit_chk.sv
module lsu_align_unit_chk
  import lsu_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              acc_valid,
  input logic              acc_ready,
  input logic [31:0]       acc_addr,
  input logic [3:0]        acc_be,
  input logic [31:0]       acc_wdata,
  input logic              acc_store,
  input logic              acc_err,
  input logic [CODE_W-1:0] acc_code
);
  // R5: failed accesses enable no lane
  a_r5_no_lanes_on_err: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_err |-> acc_be == 4'b0000);

  // R5: good accesses enable 1, 2 or 4 lanes
  a_r5_lane_count: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !acc_err |-> ($countones(acc_be) == 1 || $countones(acc_be) == 2 ||
                               $countones(acc_be) == 4));

  // R4: code matches error and direction
  a_r4_code: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> (acc_err ? (acc_code == (acc_store ? CODE_STOR_BAD : CODE_LOAD_BAD))
                           : (acc_code == CODE_NONE)));

  // R9: empty slot always accepts
  a_r9_ready_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> req_ready);

  // R9: accepted request shows up next cycle
  a_r9_capture: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> acc_valid);

  // R9: outputs hold under back-pressure
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !acc_ready |=> acc_valid && $stable(acc_addr) && $stable(acc_be) &&
      $stable(acc_wdata) && $stable(acc_err) && $stable(acc_code));
endmodule

bind lsu_align_unit lsu_align_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_addr(acc_addr),
  .acc_be(acc_be), .acc_wdata(acc_wdata), .acc_store(acc_store),
  .acc_err(acc_err), .acc_code(acc_code)
);

// File: tb/lsu_align_unit_test.sv
module lsu_align_unit_test;
  logic clk = 0;
  logic rst_n = 0;
  always #5 clk = ~clk;

  logic        req_valid = 0, req_store = 0, req_user = 0, acc_ready = 1, ld_unsigned = 0;
  logic [31:0] req_base = 0, req_wdata = 0, ld_word = 0;
  logic [15:0] req_disp = 0;
  logic [1:0]  req_size = 0, ld_lane = 0, ld_size = 0;
  logic        req_ready, acc_valid, acc_store, acc_err;
  logic [31:0] acc_addr, acc_wdata, ld_value;
  logic [3:0]  acc_be;
  logic [4:0]  acc_code;

  int checks = 0;
  int fails  = 0;

  lsu_align_unit uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_base(req_base), .req_disp(req_disp), .req_size(req_size),
    .req_store(req_store), .req_user(req_user), .req_wdata(req_wdata),
    .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_addr(acc_addr),
    .acc_be(acc_be), .acc_wdata(acc_wdata), .acc_store(acc_store),
    .acc_err(acc_err), .acc_code(acc_code), .ld_word(ld_word),
    .ld_lane(ld_lane), .ld_size(ld_size), .ld_unsigned(ld_unsigned),
    .ld_value(ld_value)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_addr(logic [31:0] b, logic [15:0] d);
    logic signed [31:0] s;
    s = 32'(signed'(d));
    return b + s;
  endfunction

  function automatic bit m_err(logic [31:0] a, logic [1:0] sz, bit user);
    bit mis;
    mis = (sz == 2'b01) ? a[0] : (sz == 2'b00) ? 1'b0 : (a[1:0] != 0);
    return mis || (user && a >= 32'h8000_0000);
  endfunction

  function automatic logic [3:0] m_be(logic [31:0] a, logic [1:0] sz);
    if (sz == 2'b00) return 4'b1000 >> a[1:0];
    if (sz == 2'b01) return a[1] ? 4'b0011 : 4'b1100;
    return 4'b1111;
  endfunction

  function automatic logic [31:0] m_wd(logic [31:0] d, logic [1:0] sz);
    if (sz == 2'b00) return {4{d[7:0]}};
    if (sz == 2'b01) return {2{d[15:0]}};
    return d;
  endfunction

  function automatic logic [31:0] m_ld(logic [31:0] w, logic [1:0] ln, logic [1:0] sz, bit u);
    logic [31:0] t;
    if (sz == 2'b00) begin
      t = (w >> (8 * (3 - ln))) & 32'hFF;
      if (!u && t[7]) t = t | 32'hFFFF_FF00;
      return t;
    end
    if (sz == 2'b01) begin
      t = ln[1] ? (w & 32'hFFFF) : (w >> 16);
      if (!u && t[15]) t = t | 32'hFFFF_0000;
      return t;
    end
    return w;
  endfunction

  task automatic do_req(input logic [31:0] b, input logic [15:0] d, input logic [1:0] sz,
                        input bit st, input bit usr, input logic [31:0] wd);
    logic [31:0] a;
    bit e;
    @(negedge clk);
    req_base = b; req_disp = d; req_size = sz; req_store = st; req_user = usr;
    req_wdata = wd; req_valid = 1; acc_ready = 1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    a = m_addr(b, d);
    e = m_err(a, sz, usr);
    chk(acc_valid === 1'b1, "R9 acc_valid after accept", 32'(acc_valid), 1);
    chk(acc_addr === a, "R1 effective address", acc_addr, a);
    chk(acc_err === e, "R2/R3 error flag", 32'(acc_err), 32'(e));
    chk(acc_store === st, "R4 store echo", 32'(acc_store), 32'(st));
    chk(acc_code === (e ? (st ? 5'd5 : 5'd4) : 5'd0), "R4 error code",
        32'(acc_code), e ? (st ? 5 : 4) : 0);
    chk(acc_be === (e ? 4'b0 : m_be(a, sz)), "R5 lane mask", 32'(acc_be),
        32'(e ? 4'b0 : m_be(a, sz)));
    if (st && !e)
      chk(acc_wdata === m_wd(wd, sz), "R6 store data", acc_wdata, m_wd(wd, sz));
  endtask

  task automatic do_ld(input logic [31:0] w, input logic [1:0] ln, input logic [1:0] sz,
                       input bit u);
    @(negedge clk);
    ld_word = w; ld_lane = ln; ld_size = sz; ld_unsigned = u;
    #1;
    chk(ld_value === m_ld(w, ln, sz, u), sz == 2'b00 ? "R7 byte load" : "R8 half/word load",
        ld_value, m_ld(w, ln, sz, u));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(acc_valid === 1'b0, "R10 reset acc_valid", 32'(acc_valid), 0);
    chk(req_ready === 1'b1, "R10 reset req_ready", 32'(req_ready), 1);
    rst_n = 1;

    // directed corners
    do_req(32'h0000_1000, 16'hFFFC, 2'b10, 1, 0, 32'h1122_3344); // R1 negative disp
    do_req(32'hFFFF_FFFE, 16'h0004, 2'b10, 0, 0, 0);              // R1 wrap
    do_req(32'h0000_0100, 16'h0002, 2'b10, 0, 0, 0);              // R2 word misaligned
    do_req(32'h0000_0101, 16'h0000, 2'b01, 1, 0, 32'hAAAA_BEEF);  // R2 half odd
    do_req(32'h0000_0103, 16'h0000, 2'b00, 1, 0, 32'h0000_00C5);  // R2 byte always ok
    do_req(32'h0000_0102, 16'h0000, 2'b01, 1, 0, 32'h1234_5678);  // R5 half offset 2
    do_req(32'h7FFF_FFFC, 16'h0000, 2'b10, 0, 1, 0);              // R3 last user word
    do_req(32'h8000_0000, 16'h0000, 2'b00, 1, 1, 32'h55);         // R3 user kernel store
    do_req(32'h8000_0000, 16'h0000, 2'b10, 1, 0, 32'hCAFE_F00D);  // R3 kernel allowed
    do_req(32'h8000_0002, 16'h0000, 2'b10, 0, 1, 0);              // R2+R3 together
    do_req(32'h0000_0010, 16'h0000, 2'b11, 1, 0, 32'h0BAD_F00D);  // size 11 as word

    // R9 back-pressure
    @(negedge clk);
    acc_ready = 0; req_valid = 1; req_base = 32'h40; req_disp = 0; req_size = 2'b10;
    req_store = 0; req_user = 0;
    @(posedge clk);
    @(negedge clk);
    req_base = 32'h80; req_size = 2'b00;
    #1;
    chk(req_ready === 1'b0, "R9 ready low under back-pressure", 32'(req_ready), 0);
    @(posedge clk);
    @(negedge clk);
    chk(acc_addr === 32'h40, "R9 held address", acc_addr, 32'h40);
    chk(acc_be === 4'b1111, "R9 held mask", 32'(acc_be), 32'hF);
    acc_ready = 1;
    #1;
    chk(req_ready === 1'b1, "R9 ready follows acc_ready", 32'(req_ready), 1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    chk(acc_addr === 32'h80 && acc_valid, "R9 second request after drain", acc_addr, 32'h80);
    @(posedge clk);
    @(negedge clk);
    chk(acc_valid === 1'b0, "R9 slot empties", 32'(acc_valid), 0);

    // load extraction directed
    do_ld(32'h80FF_7F01, 2'd0, 2'b00, 0); // R7 sign byte
    do_ld(32'h80FF_7F01, 2'd0, 2'b00, 1); // R7 zero byte
    do_ld(32'h80FF_7F01, 2'd2, 2'b00, 0); // R7 positive byte
    do_ld(32'h8001_F00F, 2'd0, 2'b01, 0); // R8 upper half signed
    do_ld(32'h8001_F00F, 2'd2, 2'b01, 1); // R8 lower half unsigned
    do_ld(32'h8001_F00F, 2'd2, 2'b01, 0); // R8 lower half signed
    do_ld(32'hDEAD_BEEF, 2'd0, 2'b10, 0); // R8 word

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [31:0] b;
      b = $urandom;
      do_req(b, 16'($urandom), 2'($urandom), 1'($urandom), 1'($urandom), $urandom);
    end
    for (int i = 0; i < 300; i++)
      do_ld($urandom, 2'($urandom), 2'($urandom), 1'($urandom));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule